// File: doc/BRIEF.md
# Octal Double-Buffered DAC Register Bank

This block keeps the digital state of an eight-channel converter. Each channel has an input word that software writes and an output word that feeds the converter. A channel moves its input word to the output word when one of three things happens: a load command names it, the hardware load pin is raised, or its latch is set to pass through. A clear, from either the clear pin or a clear command, sets both words of a channel to that channel's programmed fallback value. A per-channel gate from a supervising timer forces the output to the fallback value for as long as it is raised.

The load and clear pins come from outside the clock domain. Each passes through a two-stage synchronizer before it acts, so a pin raised before clock edge k takes effect at edge k+2. Every command strobe and configuration write takes effect at the next clock edge. The block uses the clock `clk` and an active-high synchronous reset `rst`.

Top module: `dac_bank`

## Requirements
- R1: While `rst` is high, every channel's input and output words become 0x000 if `mz_sel` is low and 0x800 if it is high. Every channel's configuration returns to selector 000 with bypass, clear-ignore and load-pin-ignore all off. No channel is pending.
- R2: When `code_we` is high, the input word of channel `code_ch` takes `code_wdata` at the next edge. No other channel's words change, and `dac_out` does not change for a channel that is not in bypass.
- R3: When `load_cmd` is high, each channel whose bit is set in `load_mask` copies its input word to its output word, but only if the input word was written since that channel's last load. The copy shows on `dac_out` after the next edge.
- R4: The load pin `ldac_pin`, after synchronization (effective at the third edge when raised before the first), copies the input word to the output word on every channel whose load-pin-ignore bit is 0, whether or not the channel is pending. Channels with the bit set to 1 do not respond.
- R5: A clear, from `clear_cmd` at the next edge or from `clr_pin` after synchronization, sets the input and output words of every channel whose clear-ignore bit is 0 to that channel's fallback value and drops its pending state. The clear takes priority over a write or a load in the same cycle. Channels whose clear-ignore bit is 1 keep both words.
- R6: The fallback value comes from the channel's 3-bit selector. 000 gives 0x000 when `mz_sel` is low and 0x800 when it is high. 001 gives 0x000, 010 gives 0x800 and 011 gives 0xFFF. Codes 100 to 111 give 0x000.
- R7: When a channel's bypass bit is 1, `dac_out` for that channel shows its input word directly.
- R8: While `gate[i]` is high, channel i's `dac_out` shows its fallback value. The input and output words are left as they are, so the earlier value comes back when the gate falls.
- R9: When `cfg_we` is high, every channel whose bit is set in `cfg_mask` takes the selector, bypass, clear-ignore and load-pin-ignore fields at the next edge. The operations of that same edge still use the old configuration.
- R10: If a write and a load reach the same channel in the same cycle, the output word takes the previous input word and the channel stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mz_sel | input | 1 | Selects the power-up and selector-000 fallback: low gives zero scale, high gives midscale |
| code_we | input | 1 | Input-word write strobe |
| code_ch | input | 3 | Channel to write |
| code_wdata | input | 12 | Word to write |
| load_cmd | input | 1 | Load command strobe |
| load_mask | input | 8 | Channels named by the load command |
| clear_cmd | input | 1 | Clear command strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 8 | Channels that take the configuration |
| cfg_dsel | input | 3 | Fallback selector |
| cfg_bypass | input | 1 | Latch pass-through |
| cfg_noclr | input | 1 | Ignore clears when 1 |
| cfg_noldac | input | 1 | Ignore the load pin when 1 |
| ldac_pin | input | 1 | Load pin, asynchronous, active high |
| clr_pin | input | 1 | Clear pin, asynchronous, active high |
| gate | input | 8 | Per-channel force to the fallback value |
| dac_out | output | 96 | Channel i's word in bits [12*i+11:12*i] |

## Verification
The assertions assume that every input except the two pins is synchronous to `clk` and steady around the rising edge, and that each pin may change at any time but is seen only through its synchronizer. The stimulus drives every input on the falling edge and moves the pins as ordinary levels, so the two-edge synchronizer latency is the only timing the reference model has to follow. The random phase lets clears overlap writes, loads and configuration changes. It keeps the clear strobes rare so that the words have time to drift away from their fallback values between clears.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

    localparam logic [2:0] DSEL_PIN  = 3'b000;
    localparam logic [2:0] DSEL_ZERO = 3'b001;
    localparam logic [2:0] DSEL_MID  = 3'b010;
    localparam logic [2:0] DSEL_FULL = 3'b011;

    typedef struct packed {
        logic [2:0] dsel;
        logic       bypass;
        logic       noclr;
        logic       noldac;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{dsel: DSEL_PIN, bypass: 1'b0, noclr: 1'b0, noldac: 1'b0};

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_CLEAR  = 2'd1,
        ACT_UPDATE = 2'd2
    } chan_act_e;

endpackage

// File: rtl/dac_bank_sync.sv
module dac_bank_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/dac_bank_chan.sv
module dac_bank_chan
    import dac_bank_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mz,
    input  logic         cfg_we,
    input  chan_cfg_t    cfg_d,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         load_sel,
    input  logic         ldac_act,
    input  logic         clr_act,
    input  logic         gate,
    output logic [W-1:0] out
);
    localparam logic [W-1:0] ZERO_W = '0;
    localparam logic [W-1:0] MID_W  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] FULL_W = '1;

    chan_cfg_t    cfg_q;
    logic [W-1:0] code_q, dac_q, dflt_val;
    logic         dirty_q, clr_eff, ldac_eff, load_eff;
    chan_act_e    act;

    always_comb begin
        case (cfg_q.dsel)
            DSEL_PIN:  dflt_val = mz ? MID_W : ZERO_W;
            DSEL_ZERO: dflt_val = ZERO_W;
            DSEL_MID:  dflt_val = MID_W;
            DSEL_FULL: dflt_val = FULL_W;
            default:   dflt_val = ZERO_W;
        endcase
    end

    assign clr_eff  = clr_act & ~cfg_q.noclr;
    assign ldac_eff = ldac_act & ~cfg_q.noldac;
    assign load_eff = ldac_eff | (load_sel & dirty_q);

    always_comb begin
        if (clr_eff)                 act = ACT_CLEAR;
        else if (load_eff || wr_hit) act = ACT_UPDATE;
        else                         act = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= mz ? MID_W : ZERO_W;
            dac_q   <= mz ? MID_W : ZERO_W;
            dirty_q <= 1'b0;
            cfg_q   <= CFG_RESET;
        end else begin
            if (cfg_we) cfg_q <= cfg_d;
            case (act)
                ACT_CLEAR: begin
                    code_q  <= dflt_val;
                    dac_q   <= dflt_val;
                    dirty_q <= 1'b0;
                end
                ACT_UPDATE: begin
                    if (load_eff) dac_q <= code_q;
                    if (wr_hit) begin
                        code_q  <= wr_data;
                        dirty_q <= 1'b1;
                    end else begin
                        dirty_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign out = gate ? dflt_val : (cfg_q.bypass ? code_q : dac_q);

    // R3: a load moves the previous input word to the output word
    assert_load_copy_R3: assert property (@(posedge clk) disable iff (rst)
        (load_eff && !clr_eff) |=> (dac_q == $past(code_q)));
    // R3: a channel that is not pending keeps its output word unless the pin loads or a clear acts
    assert_clean_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!dirty_q && !ldac_eff && !clr_eff) |=> $stable(dac_q));
    // R4: a channel that ignores the load pin keeps its output word
    assert_ldac_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (ldac_act && cfg_q.noldac && !clr_eff && !(load_sel && dirty_q)) |=> $stable(dac_q));
    // R5: a clear puts the fallback value in both words
    assert_clear_words_R5: assert property (@(posedge clk) disable iff (rst)
        clr_eff |=> (code_q == $past(dflt_val) && dac_q == $past(dflt_val) && !dirty_q));
    // R5: a clear-ignoring channel keeps its input word
    assert_clear_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_act && cfg_q.noclr && !wr_hit) |=> $stable(code_q));
    // R8: the gate leaves the input word alone
    assert_gate_keeps_code_R8: assert property (@(posedge clk) disable iff (rst)
        (gate && !wr_hit && !clr_eff) |=> $stable(code_q));
    // R10: a write always leaves the channel pending
    assert_write_pending_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !clr_eff) |=> dirty_q);
endmodule

// File: rtl/dac_bank.sv
module dac_bank
    import dac_bank_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int W           = 12,
    parameter int SYNC_STAGES = 2,
    localparam int CHW        = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mz_sel,
    input  logic             code_we,
    input  logic [CHW-1:0]   code_ch,
    input  logic [W-1:0]     code_wdata,
    input  logic             load_cmd,
    input  logic [NCH-1:0]   load_mask,
    input  logic             clear_cmd,
    input  logic             cfg_we,
    input  logic [NCH-1:0]   cfg_mask,
    input  logic [2:0]       cfg_dsel,
    input  logic             cfg_bypass,
    input  logic             cfg_noclr,
    input  logic             cfg_noldac,
    input  logic             ldac_pin,
    input  logic             clr_pin,
    input  logic [NCH-1:0]   gate,
    output logic [NCH*W-1:0] dac_out
);
    logic      ldac_s, clr_s, clr_any;
    chan_cfg_t cfg_word;

    dac_bank_sync #(.STAGES(SYNC_STAGES)) u_sync_ldac (
        .clk(clk), .rst(rst), .d(ldac_pin), .q(ldac_s));
    dac_bank_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
        .clk(clk), .rst(rst), .d(clr_pin), .q(clr_s));

    assign clr_any  = clr_s | clear_cmd;
    assign cfg_word = '{dsel: cfg_dsel, bypass: cfg_bypass, noclr: cfg_noclr, noldac: cfg_noldac};

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dac_bank_chan #(.W(W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .mz       (mz_sel),
            .cfg_we   (cfg_we & cfg_mask[i]),
            .cfg_d    (cfg_word),
            .wr_hit   (code_we && (code_ch == CHW'(i))),
            .wr_data  (code_wdata),
            .load_sel (load_cmd & load_mask[i]),
            .ldac_act (ldac_s),
            .clr_act  (clr_any),
            .gate     (gate[i]),
            .out      (dac_out[i*W +: W])
        );
    end
endmodule

// File: tb/dac_bank_test.sv
module dac_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mz_sel = 1'b1;
    logic        code_we = 1'b0;
    logic [2:0]  code_ch = '0;
    logic [11:0] code_wdata = '0;
    logic        load_cmd = 1'b0;
    logic [7:0]  load_mask = '0;
    logic        clear_cmd = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_mask = '0;
    logic [2:0]  cfg_dsel = '0;
    logic        cfg_bypass = 1'b0, cfg_noclr = 1'b0, cfg_noldac = 1'b0;
    logic        ldac_pin = 1'b0, clr_pin = 1'b0;
    logic [7:0]  gate = '0;
    logic [95:0] dac_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dac_bank uut (.*);

    // behavioural reference state
    int m_code[8], m_dac[8], m_dsel[8];
    bit m_dirty[8], m_byp[8], m_noclr[8], m_noldac[8];
    int ldq[$], clq[$];

    function automatic int fallback(int sel, bit mz);
        if (sel == 0) return mz ? 2048 : 0;
        if (sel == 2) return 2048;
        if (sel == 3) return 4095;
        return 0;
    endfunction

    function automatic int outw(int ch);
        return int'(dac_out[ch*12 +: 12]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_code[i] = mz_sel ? 2048 : 0; m_dac[i] = m_code[i]; m_dirty[i] = 0;
                m_dsel[i] = 0; m_byp[i] = 0; m_noclr[i] = 0; m_noldac[i] = 0;
            end
            ldq = '{0, 0}; clq = '{0, 0};
        end else begin
            int l_eff, c_eff;
            l_eff = ldq.pop_front(); c_eff = clq.pop_front();
            ldq.push_back(int'(ldac_pin)); clq.push_back(int'(clr_pin));
            for (int i = 0; i < 8; i++) begin
                bit wh, lh;
                if ((c_eff != 0 || clear_cmd) && !m_noclr[i]) begin
                    m_code[i] = fallback(m_dsel[i], mz_sel); m_dac[i] = m_code[i]; m_dirty[i] = 0;
                end else begin
                    wh = code_we && (int'(code_ch) == i);
                    lh = (l_eff != 0 && !m_noldac[i]) || (load_cmd && load_mask[i] && m_dirty[i]);
                    if (lh) m_dac[i] = m_code[i];
                    if (wh) begin m_code[i] = int'(code_wdata); m_dirty[i] = 1; end
                    else if (lh) m_dirty[i] = 0;
                end
                if (cfg_we && cfg_mask[i]) begin
                    m_dsel[i] = int'(cfg_dsel); m_byp[i] = cfg_bypass;
                    m_noclr[i] = cfg_noclr; m_noldac[i] = cfg_noldac;
                end
            end
        end
    end

    // compare every channel to the model once per cycle, between edges
    always begin
        @(negedge clk); #3;
        if (!done) begin
            for (int i = 0; i < 8; i++) begin
                int e;
                e = gate[i] ? fallback(m_dsel[i], mz_sel) : (m_byp[i] ? m_code[i] : m_dac[i]);
                checks++;
                if (outw(i) != e) begin
                    fails++;
                    $display("FAIL model(R2,R3,R4,R5,R6,R7,R8,R10) ch%0d t=%0t actual=%h expected=%h",
                             i, $time, outw(i), e);
                end
            end
        end
    end

    task automatic chk(string req, int ch, int exp);
        checks++;
        if (outw(ch) != exp) begin
            fails++;
            $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, outw(ch), exp);
        end
    endtask

    task automatic wr(int ch, int val);
        code_we = 1; code_ch = 3'(ch); code_wdata = 12'(val);
        @(negedge clk); code_we = 0;
    endtask

    task automatic ld(int mask);
        load_cmd = 1; load_mask = 8'(mask);
        @(negedge clk); load_cmd = 0;
    endtask

    task automatic cfg(int mask, int dsel, bit byp, bit nclr, bit nld);
        cfg_we = 1; cfg_mask = 8'(mask); cfg_dsel = 3'(dsel);
        cfg_bypass = byp; cfg_noclr = nclr; cfg_noldac = nld;
        @(negedge clk); cfg_we = 0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 0, 12'h800); chk("R1", 7, 12'h800);
        mz_sel = 0; @(negedge clk);
        chk("R1", 0, 0); chk("R1", 5, 0);
        rst = 0; @(negedge clk);

        wr(3, 12'h123);
        chk("R2", 3, 0);
        ld(8'h08);
        chk("R3", 3, 12'h123);

        code_we = 1; code_ch = 3; code_wdata = 12'h456; load_cmd = 1; load_mask = 8'h08;
        @(negedge clk); code_we = 0; load_cmd = 0;
        chk("R10", 3, 12'h123);
        ld(8'h08);
        chk("R10", 3, 12'h456);

        cfg(8'h04, 0, 1, 0, 0);
        wr(2, 12'h777);
        chk("R7", 2, 12'h777);
        chk("R9", 2, 12'h777);

        cfg(8'h02, 0, 0, 0, 1);
        wr(0, 12'h111);
        wr(1, 12'h222);
        ldac_pin = 1; @(negedge clk); ldac_pin = 0;
        @(negedge clk);
        chk("R4", 0, 0);
        @(negedge clk);
        chk("R4", 0, 12'h111); chk("R4", 1, 0);

        cfg(8'h10, 3, 0, 0, 0);
        cfg(8'h40, 2, 0, 0, 0);
        cfg(8'h80, 1, 0, 0, 0);
        cfg(8'h20, 4, 0, 0, 0);
        cfg(8'h08, 0, 0, 1, 0);
        mz_sel = 1;
        clear_cmd = 1; @(negedge clk); clear_cmd = 0;
        chk("R6", 4, 12'hFFF); chk("R6", 6, 12'h800); chk("R6", 7, 0);
        chk("R6", 5, 0); chk("R6", 0, 12'h800);
        chk("R5", 3, 12'h456);

        wr(4, 12'h321);
        ld(8'h10);
        chk("R3", 4, 12'h321);
        clr_pin = 1; @(negedge clk); clr_pin = 0;
        @(negedge clk);
        chk("R5", 4, 12'h321);
        @(negedge clk);
        chk("R5", 4, 12'hFFF);

        gate[3] = 1; #1;
        chk("R8", 3, 12'h800);
        @(negedge clk); gate[3] = 0; #1;
        chk("R8", 3, 12'h456);
        @(negedge clk);

        for (int n = 0; n < 4000; n++) begin
            code_we    = ($urandom % 3) == 0;
            code_ch    = 3'($urandom);
            code_wdata = 12'($urandom);
            load_cmd   = ($urandom % 4) == 0;
            load_mask  = 8'($urandom);
            clear_cmd  = ($urandom % 40) == 0;
            cfg_we     = ($urandom % 12) == 0;
            cfg_mask   = 8'($urandom);
            cfg_dsel   = 3'($urandom);
            cfg_bypass = ($urandom % 3) == 0;
            cfg_noclr  = ($urandom % 3) == 0;
            cfg_noldac = ($urandom % 3) == 0;
            ldac_pin   = ($urandom % 10) == 0;
            clr_pin    = ($urandom % 50) == 0;
            gate       = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            if (($urandom % 200) == 0) mz_sel = ~mz_sel;
            @(negedge clk);
        end
        code_we = 0; load_cmd = 0; clear_cmd = 0; cfg_we = 0;
        ldac_pin = 0; clr_pin = 0; gate = '0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule